// File: doc/BRIEF.md
# Block Transmit Sequencer

This block sends a run of pre-loaded transmit buffers without software between the frames. Software writes a gap value and sets the start bit. The sequencer then walks the buffer indices upward from 0 to `NBUF-1`. Before each launch it waits the programmed number of bit-time strobes. It then raises a one-hot transmit request toward the protocol engine and holds it until the engine acknowledges completion.

A buffer whose ready bit is clear at launch time is passed over. The gap is not spent again for it. The run ends in one of three ways:
- The last index is acknowledged: the start bit clears and a single-cycle done pulse is raised.
- No ready buffer is left at a launch point: same result as above.
- An abort arrives: the start bit clears, any request is withdrawn, and no done pulse is raised.

A configuration write is refused while a run is in progress, while the controller reports a frame in flight, or while the controller is not in its block-transmit operating mode. A refused write leaves the stored gap unchanged.

Top module: `blk_tx_seq`

## Requirements
- R1: After reset, `armed`, `done`, `cfg_ok`, `cfg_err` and `tx_req` are 0 and `dly_q` is 0.
- R2: A `cfg_wr` is accepted when `armed`=0, `tx_busy`=0, `blk_mode`=1 and `abort`=0. On acceptance:
  - `dly_q` takes `cfg_delay`.
  - `cfg_ok` pulses for the one cycle after the write.
  - If `cfg_start`=1, `armed` becomes 1 in that same cycle.
- R3: A `cfg_wr` while `armed`=1 or `tx_busy`=1 is refused:
  - `cfg_err` pulses in the cycle after the write.
  - `dly_q` is unchanged.
  - The armed state is unchanged.
- R4: A `cfg_wr` while `blk_mode`=0 is refused the same way, and no run starts.
- R5: Buffers are launched one at a time in ascending index order, only within 0..`NBUF-1`. `tx_req` is one-hot, with bit i requesting buffer i, and is held until `tx_ack` is sampled high.
- R6: A buffer whose `buf_rdy` bit is 0 at its launch point is skipped. The next higher ready index is launched instead, with no extra gap.
- R7: Before each launch, exactly `dly_q` `bit_tick` strobes are counted. For the first buffer, counting starts in the cycle after the start write. For later buffers, it starts in the cycle after the previous `tx_ack`. The request rises in the cycle after the count reaches zero, so with `bit_tick` held high it rises `dly_q`+2 cycles after the start write or `tx_ack` cycle.
- R8: After the acknowledgement of buffer `NBUF-1`, or at a launch point with no ready buffer left, `armed` clears and `done` is 1 for exactly one cycle.
- R9: `abort` clears `armed` and `tx_req` at the next edge. No `done` pulse is raised and no further buffer is launched.
- R10: `armed` reads 1 from the start write until the run ends, and every request is raised only while `armed`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_start | input | 1 | Start bit carried by the write |
| cfg_delay | input | DLY_W | Gap value carried by the write |
| cfg_ok | output | 1 | Write accepted, one-cycle pulse |
| cfg_err | output | 1 | Write refused, one-cycle pulse |
| dly_q | output | DLY_W | Stored gap value |
| armed | output | 1 | Start bit readback; 1 means busy |
| done | output | 1 | Run completed, one-cycle pulse |
| abort | input | 1 | Synchronous stop request |
| blk_mode | input | 1 | Controller is in block-transmit operating mode |
| tx_busy | input | 1 | Controller has a frame in flight |
| bit_tick | input | 1 | Bit-time strobe for the gap counter |
| buf_rdy | input | NBUF | Ready bits of the buffers |
| tx_req | output | NBUF | One-hot transmit request |
| tx_ack | input | 1 | Transmit completion for the current request |

## Verification
A wrong index register shows up at the very next launch: the one-hot request names a buffer other than the lowest ready index above the previous one. A wrong gap counter moves the request edge away from the cycle after the last counted strobe, and the bench sees this on the first buffer of a run. If the state register fails to leave its running state, `armed` stays high and `done` never pulses, which shows one cycle after the final acknowledgement. A leaking configuration gate changes `dly_q` in the cycle after a refused write.

// File: rtl/blk_tx_seq.sv
module blk_tx_seq #(
  parameter int NBUF  = 8,
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_start,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             cfg_ok,
  output logic             cfg_err,
  output logic [DLY_W-1:0] dly_q,
  output logic             armed,
  output logic             done,
  input  logic             abort,
  input  logic             blk_mode,
  input  logic             tx_busy,
  input  logic             bit_tick,
  input  logic [NBUF-1:0]  buf_rdy,
  output logic [NBUF-1:0]  tx_req,
  input  logic             tx_ack
);
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} st_t;

  st_t             st;
  logic [IW:0]     idx;
  logic [IW-1:0]   cur;
  logic [DLY_W-1:0] cnt;
  logic            nxt_vld;
  logic [IW-1:0]   nxt;
  logic            accept;

  assign armed  = (st != S_IDLE);
  assign accept = cfg_wr && !abort && (st == S_IDLE) && !tx_busy && blk_mode;

  always_comb begin
    nxt_vld = 1'b0;
    nxt     = '0;
    for (int i = NBUF-1; i >= 0; i--)
      if (buf_rdy[i] && (i >= int'(idx))) begin
        nxt_vld = 1'b1;
        nxt     = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      cur     <= '0;
      cnt     <= '0;
      dly_q   <= '0;
      tx_req  <= '0;
      done    <= 1'b0;
      cfg_ok  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      cfg_ok  <= cfg_wr && accept;
      cfg_err <= cfg_wr && !accept;
      if (abort) begin
        st     <= S_IDLE;
        tx_req <= '0;
      end else begin
        case (st)
          S_IDLE:
            if (accept) begin
              dly_q <= cfg_delay;
              if (cfg_start) begin
                st  <= S_WAIT;
                cnt <= cfg_delay;
                idx <= '0;
              end
            end
          S_WAIT:
            if (cnt != '0) begin
              if (bit_tick) cnt <= cnt - 1'b1;
            end else if (nxt_vld) begin
              st     <= S_SEND;
              cur    <= nxt;
              tx_req <= NBUF'(1) << nxt;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          S_SEND:
            if (tx_ack) begin
              tx_req <= '0;
              if (cur == IW'(NBUF-1)) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                st  <= S_WAIT;
                cnt <= dly_q;
                idx <= (IW+1)'(cur) + 1'b1;
              end
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_ok ^ cfg_err));
  a_r3_refused_keeps_delay: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (dly_q == $past(dly_q)));
  a_r5_onehot_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_req));
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req != '0 && !tx_ack && !abort) |=> (tx_req == $past(tx_req)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!armed && tx_req == '0) ##1 !done);
  a_r9_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!armed && tx_req == '0 && !done));
  a_r10_req_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req != '0) |-> armed);
endmodule

// File: tb/tb_blk_tx_seq.sv
`timescale 1ns/1ps
module tb_blk_tx_seq;
  localparam int NBUF = 8;
  localparam int DLY_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_start = 0, abort = 0, blk_mode = 1, tx_busy = 0, bit_tick = 0, tx_ack = 0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic [NBUF-1:0] buf_rdy = '0;
  logic cfg_ok, cfg_err, armed, done;
  logic [DLY_W-1:0] dly_q;
  logic [NBUF-1:0] tx_req;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  blk_tx_seq #(.NBUF(NBUF), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_delay(cfg_delay),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err), .dly_q(dly_q), .armed(armed), .done(done),
    .abort(abort), .blk_mode(blk_mode), .tx_busy(tx_busy), .bit_tick(bit_tick),
    .buf_rdy(buf_rdy), .tx_req(tx_req), .tx_ack(tx_ack));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic int first_ready(input logic [NBUF-1:0] m, input int from);
    for (int i = from; i < NBUF; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic longint req_of(input int i);
    return (i < 0) ? 0 : (longint'(1) << i);
  endfunction

  task automatic cfg_write(input int d, input bit s);
    cfg_wr = 1; cfg_delay = DLY_W'(d); cfg_start = s;
    @(negedge clk);
    cfg_wr = 0; cfg_start = 0;
  endtask

  task automatic run_seq(input int d, input logic [NBUF-1:0] rdy, input bit rnd);
    int idx_exp, cnt, pend, lat;
    bit waiting, fin;
    buf_rdy = rdy;
    cfg_write(d, 1);
    chk(cfg_ok == 1, "R2 start accepted", cfg_ok, 1);
    chk(armed == 1, "R10 armed after start", armed, 1);
    idx_exp = first_ready(rdy, 0);
    cnt = 0; pend = 0; lat = 0; waiting = 1; fin = 0;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      tx_ack = 0;
      if (waiting) begin
        if (tx_req != '0) begin
          waiting = 0;
          chk(cnt == d, "R7 strobes before launch", cnt, d);
          chk(tx_req == req_of(idx_exp), "R5 R6 launched index", tx_req, req_of(idx_exp));
          chk(armed == 1, "R10 armed during send", armed, 1);
          lat = $urandom_range(0, 3);
        end else if (!armed) begin
          chk(idx_exp < 0, "R8 ended with ready buffer left", idx_exp, -1);
          chk(done == 1, "R8 done pulse", done, 1);
          fin = 1;
        end else begin
          cnt += pend;
          bit_tick = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
          pend = bit_tick;
        end
      end else begin
        chk(tx_req == req_of(idx_exp), "R5 request held", tx_req, req_of(idx_exp));
        bit_tick = 1'($urandom_range(0, 1));
        if (lat == 0) begin
          tx_ack = 1;
          waiting = 1; cnt = 0; pend = 0;
          idx_exp = first_ready(rdy, idx_exp + 1);
        end else lat--;
      end
      if (!fin) @(negedge clk);
    end
    tx_ack = 0;
    chk(fin == 1, "R8 run completes", fin, 1);
    @(negedge clk);
    chk(done == 0, "R8 done single cycle", done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(armed == 0 && done == 0 && tx_req == 0, "R1 reset outputs", {armed, done, tx_req}, 0);
    chk(cfg_ok == 0 && cfg_err == 0 && dly_q == 0, "R1 reset config", dly_q, 0);

    cfg_write(9, 0);
    chk(cfg_ok == 1 && cfg_err == 0, "R2 plain write ok", cfg_ok, 1);
    chk(dly_q == 9, "R2 delay stored", dly_q, 9);
    chk(armed == 0, "R2 no start without bit", armed, 0);

    blk_mode = 0;
    cfg_write(3, 1);
    chk(cfg_err == 1, "R4 wrong mode refused", cfg_err, 1);
    chk(dly_q == 9, "R4 delay kept", dly_q, 9);
    chk(armed == 0, "R4 no run", armed, 0);
    blk_mode = 1;

    tx_busy = 1;
    cfg_write(4, 1);
    chk(cfg_err == 1, "R3 busy refused", cfg_err, 1);
    chk(dly_q == 9, "R3 delay kept busy", dly_q, 9);
    chk(armed == 0, "R3 no run busy", armed, 0);
    tx_busy = 0;

    run_seq(3, 8'hFF, 0);
    run_seq(0, 8'h81, 0);
    run_seq(2, 8'h00, 1);
    run_seq(1, 8'h5A, 1);

    buf_rdy = 8'hFF; bit_tick = 1;
    cfg_write(20, 1);
    chk(cfg_ok == 1, "R2 long run accepted", cfg_ok, 1);
    cfg_write(7, 1);
    chk(cfg_err == 1, "R3 armed refused", cfg_err, 1);
    chk(dly_q == 20, "R3 delay kept armed", dly_q, 20);
    chk(armed == 1, "R3 still armed", armed, 1);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(armed == 0 && tx_req == 0, "R9 abort in wait", armed, 0);
    chk(done == 0, "R9 no done on abort", done, 0);
    begin
      int bad = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (tx_req != 0 || armed) bad++;
      end
      chk(bad == 0, "R9 nothing launched after abort", bad, 0);
    end

    cfg_write(0, 1);
    for (int k = 0; k < 5 && tx_req == 0; k++) @(negedge clk);
    chk(tx_req == 8'h01, "R5 first request", tx_req, 1);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(armed == 0 && tx_req == 0 && done == 0, "R9 abort in send", tx_req, 0);

    for (int n = 0; n < 30; n++)
      run_seq($urandom_range(0, 6), NBUF'($urandom), 1);

    report();
  end
endmodule